// File: doc/BRIEF.md
# Desktop bus transaction sequencer

This block sits between a host-side byte shift register and a peripheral desktop-bus responder. The host advances the transaction one byte at a time. For each step it presents a 2-bit transaction state, a shift direction and, when sending, a byte. The block keeps an outgoing command buffer and an incoming reply buffer. It accepts or returns a byte only when the parity of the relevant buffer index agrees with the host's even/odd state code. It answers on an active-low interrupt line and a one-cycle ready pulse.

A host step in the idle state with the direction set to read, made while command bytes are pending, launches the request. The whole command goes to the responder in that same cycle. The responder answers combinationally with an error flag, a reply length and the reply bytes. The first reply byte is returned at once, and the rest are fetched by later even/odd read steps.

Top module: `dbus_txn_seq`

## Requirements
- R1: After reset, int_no is 1, ready_o is 0, host_byte_o is 0x00 and req_len_o is 0.
- R2: State codes are 0 = new, 1 = even, 2 = odd, 3 = idle, and dir_out_i = 1 means the host sends a byte. A send step in the new state restarts the command buffer, stores the byte at position 0 (req_len_o becomes 1), drives int_no low and pulses ready_o.
- R3: A send step in the even state is accepted only when the command count is odd. In the odd state it is accepted only when the count is even. An accepted byte is appended, int_no goes low and ready_o pulses. A rejected byte leaves the count unchanged, sets int_no high and gives no ready pulse.
- R4: A send step in the idle state stores nothing and sets int_no high.
- R5: The command buffer holds 16 bytes. A send step on a full buffer is dropped and sets int_no high.
- R6: A read step in the idle state with a non-zero command count raises req_valid_o during the step cycle. In that cycle req_len_o is the count and byte k of req_data_o sits at bits 8k+7..8k. Afterwards the command count is 0 and the reply index restarts.
- R7: A read step in the idle state with an empty command buffer issues no request, leaves host_byte_o unchanged and sets int_no high.
- R8: If the responder flags an error, host_byte_o becomes 0xFF, ready_o pulses and int_no goes high. Later even/odd read steps pulse ready_o with int_no high.
- R9: A successful launch with reply length 0 returns no byte: host_byte_o is unchanged, there is no ready pulse and int_no is high.
- R10: On a successful launch the first reply byte is returned. Each later read step whose state parity matches the reply index (even needs an odd index, odd needs an even index) returns the next byte and pulses ready_o. A mismatch returns nothing and sets int_no high.
- R11: A read step in the even or odd state after the reply is exhausted returns 0x00, pulses ready_o and keeps int_no high.
- R12: A returned byte of 0x00 or 0xFF counts as no data: ready_o pulses but int_no stays high. Any other returned byte drives int_no low.
- R13: A read step in the new state changes nothing at the outputs except setting int_no high.
- R14: Without a step, int_no and host_byte_o hold their values and ready_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One host transaction step this cycle |
| state_i | input | 2 | Transaction state code |
| dir_out_i | input | 1 | 1: host sends host_byte_i, 0: host reads |
| host_byte_i | input | 8 | Byte shifted out by the host |
| host_byte_o | output | 8 | Byte presented to the host shift register |
| int_no | output | 1 | Transfer indication, active low |
| ready_o | output | 1 | One-cycle pulse: byte handled |
| req_valid_o | output | 1 | Request to responder, during the step cycle |
| req_len_o | output | 5 | Command byte count |
| req_data_o | output | 128 | Command bytes, byte k at bits 8k+7..8k |
| rsp_err_i | input | 1 | Responder error flag |
| rsp_len_i | input | 5 | Reply length (values above 16 are clamped) |
| rsp_data_i | input | 128 | Reply bytes, byte k at bits 8k+7..8k |

## Verification
The request port is combinational, so req_valid_o, req_len_o and req_data_o are sampled one time step after the step inputs are driven, inside the step cycle. int_no, host_byte_o and ready_o are registered and change on the edge that closes the step cycle. The bench drives each step at a falling edge, holds it for one cycle and checks these outputs at the next falling edge. At that point the ready pulse is still high. The parity walks and the full-buffer case are chosen so that each accept or reject falls on a known index.

// File: rtl/dbseq_pkg.sv
package dbseq_pkg;
  typedef enum logic [1:0] {
    ST_NEW  = 2'd0,
    ST_EVEN = 2'd1,
    ST_ODD  = 2'd2,
    ST_IDLE = 2'd3
  } txn_state_e;

  // even state wants an odd index, odd state wants an even index
  function automatic logic parity_ok(txn_state_e s, logic idx_lsb);
    return (s == ST_EVEN && idx_lsb) || (s == ST_ODD && !idx_lsb);
  endfunction

  function automatic logic is_blank(logic [7:0] b);
    return (b == 8'h00) || (b == 8'hFF);
  endfunction
endpackage

// File: rtl/dbseq_cmd_buf.sv
module dbseq_cmd_buf #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int IDXW = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 restart_i,
  input  logic                 wr_i,
  input  logic [7:0]           byte_i,
  input  logic                 flush_i,
  output logic [IDXW-1:0]      idx_o,
  output logic [DEPTH*8-1:0]   data_o
);
  logic [7:0]      mem_q [DEPTH];
  logic [IDXW-1:0] idx_q;
  logic [IDXW-1:0] slot;

  assign slot = restart_i ? '0 : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_i) begin
      mem_q[slot[AW-1:0]] <= byte_i;
      idx_q <= slot + 1'b1;
    end else if (flush_i) begin
      idx_q <= '0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign data_o[g*8 +: 8] = mem_q[g];
  end

  assign idx_o = idx_q;

  assert_wr_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (restart_i || idx_q < IDXW'(DEPTH)));
endmodule

// File: rtl/dbseq_rsp_buf.sv
module dbseq_rsp_buf #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int IDXW = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [IDXW-1:0]      len_i,
  input  logic [DEPTH*8-1:0]   data_i,
  input  logic                 adv_i,
  output logic [IDXW-1:0]      idx_o,
  output logic [IDXW-1:0]      len_o,
  output logic [7:0]           byte_o
);
  logic [7:0]      mem_q [DEPTH];
  logic [IDXW-1:0] idx_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      len_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (load_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= data_i[i*8 +: 8];
      len_q <= len_i;
      // byte 0 is handed out at launch time
      idx_q <= (len_i != '0) ? IDXW'(1) : '0;
    end else if (adv_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign len_o  = len_q;
  assign byte_o = mem_q[idx_q[AW-1:0]];

  assert_rd_in_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (idx_q < len_q));
endmodule

// File: rtl/dbus_txn_seq.sv
module dbus_txn_seq
  import dbseq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [1:0]         state_i,
  input  logic               dir_out_i,
  input  logic [7:0]         host_byte_i,
  output logic [7:0]         host_byte_o,
  output logic               int_no,
  output logic               ready_o,
  output logic               req_valid_o,
  output logic [IDXW-1:0]    req_len_o,
  output logic [DEPTH*8-1:0] req_data_o,
  input  logic               rsp_err_i,
  input  logic [IDXW-1:0]    rsp_len_i,
  input  logic [DEPTH*8-1:0] rsp_data_i
);
  txn_state_e      st;
  logic [IDXW-1:0] cmd_idx, rsp_idx, rsp_len, rsp_len_clamp, load_len;
  logic [7:0]      rsp_byte, nxt_byte;
  logic            wr, restart, flush, load, adv, req, xfer, rdy;
  logic [7:0]      host_byte_q;
  logic            int_nq, ready_q;

  assign st            = txn_state_e'(state_i);
  assign rsp_len_clamp = (rsp_len_i > IDXW'(DEPTH)) ? IDXW'(DEPTH) : rsp_len_i;
  assign load_len      = rsp_err_i ? '0 : rsp_len_clamp;

  always_comb begin
    wr = 1'b0; restart = 1'b0; flush = 1'b0; load = 1'b0; adv = 1'b0;
    req = 1'b0; xfer = 1'b0; rdy = 1'b0;
    nxt_byte = host_byte_q;
    if (step_i) begin
      if (dir_out_i) begin
        unique case (st)
          ST_NEW: begin wr = 1'b1; restart = 1'b1; end
          ST_EVEN, ST_ODD: wr = parity_ok(st, cmd_idx[0]) && (cmd_idx < IDXW'(DEPTH));
          default: ;
        endcase
        xfer = wr;
        rdy  = wr;
      end else begin
        unique case (st)
          ST_NEW: ;
          ST_EVEN, ST_ODD: begin
            if (rsp_len == '0) begin
              rdy = 1'b1;
            end else if (rsp_idx >= rsp_len) begin
              nxt_byte = 8'h00;
              rdy      = 1'b1;
            end else if (parity_ok(st, rsp_idx[0])) begin
              adv      = 1'b1;
              nxt_byte = rsp_byte;
              rdy      = 1'b1;
              xfer     = !is_blank(rsp_byte);
            end
          end
          default: begin
            if (cmd_idx != '0) begin
              req   = 1'b1;
              flush = 1'b1;
              load  = 1'b1;
              if (rsp_err_i) begin
                nxt_byte = 8'hFF;
                rdy      = 1'b1;
              end else if (rsp_len_clamp != '0) begin
                nxt_byte = rsp_data_i[7:0];
                rdy      = 1'b1;
                xfer     = !is_blank(rsp_data_i[7:0]);
              end
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_byte_q <= '0;
      int_nq      <= 1'b1;
      ready_q     <= 1'b0;
    end else begin
      ready_q <= rdy;
      if (step_i) begin
        host_byte_q <= nxt_byte;
        int_nq      <= !xfer;
      end
    end
  end

  dbseq_cmd_buf #(.DEPTH(DEPTH)) u_cmd (
    .clk_i, .rst_ni,
    .restart_i(restart), .wr_i(wr), .byte_i(host_byte_i), .flush_i(flush),
    .idx_o(cmd_idx), .data_o(req_data_o)
  );

  dbseq_rsp_buf #(.DEPTH(DEPTH)) u_rsp (
    .clk_i, .rst_ni,
    .load_i(load), .len_i(load_len), .data_i(rsp_data_i), .adv_i(adv),
    .idx_o(rsp_idx), .len_o(rsp_len), .byte_o(rsp_byte)
  );

  assign host_byte_o = host_byte_q;
  assign int_no      = int_nq;
  assign ready_o     = ready_q;
  assign req_valid_o = req;
  assign req_len_o   = cmd_idx;

  assert_int_low_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_no) |-> ready_o);
  assert_hold_without_step_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(int_no) && $stable(host_byte_o) && !ready_o));
  assert_launch_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> (req_len_o == '0));
endmodule

// File: tb/dbus_txn_seq_tb.sv
`timescale 1ns/1ps
module dbus_txn_seq_tb_top;
  localparam int DEPTH = 16;
  localparam int IDXW  = $clog2(DEPTH + 1);
  localparam logic [1:0] S_NEW = 2'd0, S_EVEN = 2'd1, S_ODD = 2'd2, S_IDLE = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic step = 1'b0, dir = 1'b0;
  logic [1:0] state = 2'd3;
  logic [7:0] hbyte = '0;
  logic [7:0] host_byte_o;
  logic int_no, ready_o, req_valid_o;
  logic [IDXW-1:0] req_len_o;
  logic [DEPTH*8-1:0] req_data_o;
  logic rsp_err = 1'b0;
  logic [IDXW-1:0] rsp_len = '0;
  logic [DEPTH*8-1:0] rsp_data = '0;

  logic cap_req;
  logic [IDXW-1:0] cap_len;
  logic [DEPTH*8-1:0] cap_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbus_txn_seq #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .state_i(state), .dir_out_i(dir),
    .host_byte_i(hbyte), .host_byte_o(host_byte_o), .int_no(int_no), .ready_o(ready_o),
    .req_valid_o(req_valid_o), .req_len_o(req_len_o), .req_data_o(req_data_o),
    .rsp_err_i(rsp_err), .rsp_len_i(rsp_len), .rsp_data_i(rsp_data)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step_once(input logic [1:0] st, input logic d, input logic [7:0] b);
    @(negedge clk);
    state = st; dir = d; hbyte = b; step = 1'b1;
    #1;
    cap_req = req_valid_o; cap_len = req_len_o; cap_data = req_data_o;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic expect_out(input string rq, input int b, input int in, input int rd);
    chk(rq, "host_byte", host_byte_o, b);
    chk(rq, "int_n", int_no, in);
    chk(rq, "ready", ready_o, rd);
  endtask

  task automatic t_reset;
    expect_out("R1", 8'h00, 1, 0);
    chk("R1", "req_len", req_len_o, 0);
  endtask

  task automatic t_new_out;
    step_once(S_NEW, 1, 8'h11);
    chk("R2", "int_n", int_no, 0);
    chk("R2", "ready", ready_o, 1);
    chk("R2", "req_len", req_len_o, 1);
  endtask

  task automatic t_parity_out;
    step_once(S_EVEN, 1, 8'h22);
    chk("R3", "even accept int_n", int_no, 0);
    chk("R3", "even accept len", req_len_o, 2);
    step_once(S_EVEN, 1, 8'h99);
    chk("R3", "even reject int_n", int_no, 1);
    chk("R3", "even reject ready", ready_o, 0);
    chk("R3", "even reject len", req_len_o, 2);
    step_once(S_ODD, 1, 8'h33);
    chk("R3", "odd accept int_n", int_no, 0);
    chk("R3", "odd accept len", req_len_o, 3);
    step_once(S_ODD, 1, 8'h98);
    chk("R3", "odd reject int_n", int_no, 1);
    chk("R3", "odd reject len", req_len_o, 3);
  endtask

  task automatic t_idle_out;
    step_once(S_NEW, 1, 8'h11);
    step_once(S_EVEN, 1, 8'h22);
    step_once(S_ODD, 1, 8'h33);
    step_once(S_IDLE, 1, 8'h55);
    chk("R4", "int_n", int_no, 1);
    chk("R4", "ready", ready_o, 0);
    chk("R4", "req_len", req_len_o, 3);
  endtask

  task automatic t_launch_walk;
    rsp_err = 0; rsp_len = 3; rsp_data = '0;
    rsp_data[23:0] = 24'h838281;
    step_once(S_IDLE, 0, 8'h00);
    chk("R6", "req_valid", cap_req, 1);
    chk("R6", "req_len", cap_len, 3);
    chk("R6", "req byte0", cap_data[7:0], 8'h11);
    chk("R6", "req byte1", cap_data[15:8], 8'h22);
    chk("R6", "req byte2", cap_data[23:16], 8'h33);
    chk("R6", "len after", req_len_o, 0);
    expect_out("R10", 8'h81, 0, 1);
    step_once(S_EVEN, 0, 8'h00);
    expect_out("R10", 8'h82, 0, 1);
    step_once(S_EVEN, 0, 8'h00);
    expect_out("R10", 8'h82, 1, 0);
    step_once(S_ODD, 0, 8'h00);
    expect_out("R10", 8'h83, 0, 1);
    step_once(S_ODD, 0, 8'h00);
    expect_out("R11", 8'h00, 1, 1);
    step_once(S_EVEN, 0, 8'h00);
    expect_out("R11", 8'h00, 1, 1);
  endtask

  task automatic t_idle_empty;
    step_once(S_IDLE, 0, 8'h00);
    chk("R7", "req_valid", cap_req, 0);
    expect_out("R7", 8'h00, 1, 0);
  endtask

  task automatic t_new_in;
    step_once(S_NEW, 1, 8'h44);
    step_once(S_NEW, 0, 8'h00);
    expect_out("R13", 8'h00, 1, 0);
    chk("R13", "req_len", req_len_o, 1);
  endtask

  task automatic t_err;
    step_once(S_NEW, 1, 8'h2A);
    rsp_err = 1; rsp_len = 4;
    step_once(S_IDLE, 0, 8'h00);
    chk("R8", "req_valid", cap_req, 1);
    expect_out("R8", 8'hFF, 1, 1);
    rsp_err = 0;
    step_once(S_EVEN, 0, 8'h00);
    expect_out("R8", 8'hFF, 1, 1);
  endtask

  task automatic t_zero;
    step_once(S_NEW, 1, 8'h3C);
    rsp_err = 0; rsp_len = 0;
    step_once(S_IDLE, 0, 8'h00);
    chk("R9", "req_valid", cap_req, 1);
    expect_out("R9", 8'hFF, 1, 0);
  endtask

  task automatic t_blanks;
    step_once(S_NEW, 1, 8'h01);
    rsp_len = 3; rsp_data = '0;
    rsp_data[23:0] = 24'h5A00FF;
    step_once(S_IDLE, 0, 8'h00);
    expect_out("R12", 8'hFF, 1, 1);
    step_once(S_EVEN, 0, 8'h00);
    expect_out("R12", 8'h00, 1, 1);
    step_once(S_ODD, 0, 8'h00);
    expect_out("R12", 8'h5A, 0, 1);
  endtask

  task automatic t_full;
    step_once(S_NEW, 1, 8'hA0);
    for (int k = 1; k < DEPTH; k++) step_once((k % 2) ? S_EVEN : S_ODD, 1, 8'(8'hA0 + k));
    chk("R5", "last accept int_n", int_no, 0);
    chk("R5", "full len", req_len_o, DEPTH);
    step_once(S_ODD, 1, 8'hEE);
    chk("R5", "overflow int_n", int_no, 1);
    chk("R5", "overflow ready", ready_o, 0);
    chk("R5", "overflow len", req_len_o, DEPTH);
  endtask

  task automatic t_no_step;
    step_once(S_EVEN, 1, 8'h00);
    repeat (3) @(negedge clk);
    chk("R14", "int_n", int_no, 1);
    chk("R14", "ready", ready_o, 0);
    chk("R14", "host_byte", host_byte_o, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_new_out();
    t_parity_out();
    t_idle_out();
    t_launch_walk();
    t_idle_empty();
    t_new_in();
    t_err();
    t_zero();
    t_blanks();
    t_full();
    t_no_step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule